// File: doc/BRIEF.md
# Reference Clock Activity Monitor

This block watches two reference clocks, one feeding the main timing loop and one feeding an auxiliary loop, using a fast system clock. Each reference is brought into the system clock domain through a two-flop synchronizer. A counter then measures the time since the last rising edge. When that time passes a programmed number of expected reference periods, the channel declares a no-activity event. It then raises an isolate (mini-holdover) request so that its loop stops following the reference.

A policy bit decides whether the event is also treated as loss of lock. With the policy clear, the loop resumes with nearest-edge (±180°) tracking as soon as an edge returns. With it set, the loop goes to a loss-of-lock state and signals wide-range (±360°) phase/frequency relocking. That state holds until the loop reports phase lock again. The main channel records events in a sticky failure bit, which can drive an interrupt and an output pin. The auxiliary channel only reports changes of its lock indication. Configuration and status go through a simple strobe register bus with combinational reads.

Top module: `ref_activity_mon`

## Requirements
- R1: With limit L = period × miss-count (both from registers, L nonzero), a channel's hold output rises exactly one clock after its edge-free counter reaches L. The counter is cleared in the clock after a synchronized rising edge is seen, and otherwise counts up to L.
- R2: A limit of zero (period or miss-count of 0) disables a channel: its hold output never rises.
- R3: In hold, a synchronized rising edge ends the hold in the next clock. With the policy bit (CTRL bit 0) at 0, the wide-relock output stays low throughout.
- R4: With the policy bit at 1, an event sets the wide-relock output together with hold. Wide-relock stays high after the edge returns, until the loop's locked input is seen high. Each change of the main wide-relock output sets sticky STATUS bit 1.
- R5: A main-channel event sets sticky STATUS bit 0 two clocks after the counter reaches L. Writing 1 to a STATUS bit at address 4 clears it, writing 0 leaves it unchanged, and a set in the same clock takes priority over the clear.
- R6: The interrupt output is high exactly when some STATUS bit and the matching enable bit at address 5 are both 1.
- R7: The failure pin equals STATUS bit 0 when CTRL bit 1 is 1, and is 0 otherwise.
- R8: Auxiliary-channel events never set STATUS bit 0. The auxiliary lock output is the inverse of its wide-relock state, and each change of it sets STATUS bit 2.
- R9: After reset, the registers read: CTRL (addr 0) = 0, main period (addr 1) = 16, auxiliary period (addr 2) = 16, miss counts (addr 3, main in bits 2:0, auxiliary in bits 10:8) = 0x0202, STATUS (addr 4) = 0, enables (addr 5) = 0. Address 6 reads live state as {aux_lock, aux_hold, main_wide, main_hold} in bits 3:0.
- R10: A reference input level is seen by edge detection only after two system-clock flops, so a rising edge clears the counter three clocks after the pin is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_main_i | input | 1 | Reference clock of the main loop (asynchronous) |
| ref_aux_i | input | 1 | Reference clock of the auxiliary loop (asynchronous) |
| main_locked_i | input | 1 | Main loop reports phase lock |
| aux_locked_i | input | 1 | Auxiliary loop reports phase lock |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid while rd_en_i is high |
| main_hold_o | output | 1 | Main loop isolate / mini-holdover request |
| main_wide_o | output | 1 | Main loop in loss-of-lock, use ±360° relocking |
| aux_hold_o | output | 1 | Auxiliary loop isolate request |
| aux_wide_o | output | 1 | Auxiliary loop in loss-of-lock, use ±360° relocking |
| aux_lock_o | output | 1 | Auxiliary lock indication |
| irq_o | output | 1 | Interrupt request |
| fail_pin_o | output | 1 | Reference-failure output pin |

## Verification
The embedded properties check four things every cycle: that an expired counter always leads to hold, that a zero limit never does, that a cleared policy never produces wide-relock, and that wide-relock holds until lock is reported. They also check that the failure bit stays set until it is written and is set only by the main channel's event pulse. The exact latency from a reference level change through the synchronizer to hold release, the loss-of-lock sequence ending on the locked input, and the register defaults can only be shown by the bench. The same applies to write-one-to-clear, interrupt masking, the pin gating and the separation of the auxiliary channel's status. The bench's reference model checks all of these against the outputs on every clock.

// File: rtl/actmon_pkg.sv
package actmon_pkg;

    typedef enum logic [1:0] {
        ST_TRACK     = 2'd0,
        ST_HOLD_NEAR = 2'd1,
        ST_HOLD_LOL  = 2'd2,
        ST_RELOCK    = 2'd3
    } chan_state_e;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_PER_M = 3'd1;
    localparam logic [2:0] A_PER_A = 3'd2;
    localparam logic [2:0] A_MISS  = 3'd3;
    localparam logic [2:0] A_STAT  = 3'd4;
    localparam logic [2:0] A_IEN   = 3'd5;
    localparam logic [2:0] A_LIVE  = 3'd6;

    localparam int NSTAT     = 3;
    localparam int SB_FAIL   = 0;
    localparam int SB_MLOL   = 1;
    localparam int SB_ALOCK  = 2;
    localparam int MISS_AOFS = 8;

    function automatic logic st_is_hold(chan_state_e s);
        return (s == ST_HOLD_NEAR) || (s == ST_HOLD_LOL);
    endfunction

    function automatic logic st_is_wide(chan_state_e s);
        return (s == ST_HOLD_LOL) || (s == ST_RELOCK);
    endfunction

endpackage

// File: rtl/actmon_sync.sv
module actmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int PW = STAGES + 1;

    typedef struct packed {
        logic [PW-1:0] pipe;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.pipe = {sync_q.pipe[PW-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise_o = sync_q.pipe[STAGES-1] & ~sync_q.pipe[STAGES];

endmodule

// File: rtl/actmon_chan.sv
module actmon_chan
    import actmon_pkg::*;
#(
    parameter int LIM_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic [LIM_W-1:0] lim_i,
    input  logic             policy_i,
    input  logic             locked_i,
    output logic             hold_o,
    output logic             wide_o,
    output logic             evt_o,
    output logic             chg_o
);
    typedef struct packed {
        chan_state_e      st;
        logic [LIM_W-1:0] cnt;
        logic             evt;
        logic             chg;
    } chan_t;

    chan_t ch_d, ch_q;
    logic  expired;

    always_comb begin
        ch_d     = ch_q;
        ch_d.evt = 1'b0;
        expired  = (lim_i != '0) && (ch_q.cnt >= lim_i);

        if (edge_i)              ch_d.cnt = '0;
        else if (ch_q.cnt < lim_i) ch_d.cnt = ch_q.cnt + 1'b1;

        unique case (ch_q.st)
            ST_TRACK: begin
                if (expired) begin
                    ch_d.st  = policy_i ? ST_HOLD_LOL : ST_HOLD_NEAR;
                    ch_d.evt = 1'b1;
                end
            end
            ST_HOLD_NEAR: if (edge_i) ch_d.st = ST_TRACK;
            ST_HOLD_LOL:  if (edge_i) ch_d.st = ST_RELOCK;
            ST_RELOCK: begin
                if (expired) begin
                    ch_d.st  = ST_HOLD_LOL;
                    ch_d.evt = 1'b1;
                end else if (locked_i) begin
                    ch_d.st = ST_TRACK;
                end
            end
            default: ch_d.st = ST_TRACK;
        endcase

        ch_d.chg = st_is_wide(ch_d.st) != st_is_wide(ch_q.st);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= '{st: ST_TRACK, cnt: '0, evt: 1'b0, chg: 1'b0};
        else        ch_q <= ch_d;
    end

    assign hold_o = st_is_hold(ch_q.st);
    assign wide_o = st_is_wide(ch_q.st);
    assign evt_o  = ch_q.evt;
    assign chg_o  = ch_q.chg;

    assert_expire_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.st == ST_TRACK && lim_i != '0 && ch_q.cnt >= lim_i) |=> hold_o);

    assert_zero_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_i == '0 && !hold_o) |=> !hold_o);

    assert_near_no_wide_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!policy_i && !wide_o) |=> !wide_o);

    assert_wide_until_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_o && !locked_i) |=> wide_o);

endmodule

// File: rtl/actmon_regs.sv
module actmon_regs
    import actmon_pkg::*;
#(
    parameter int DW     = 16,
    parameter int AW     = 3,
    parameter int PER_W  = 16,
    parameter int MISS_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    input  logic [NSTAT-1:0]  set_i,
    input  logic [3:0]        live_i,
    output logic              policy_o,
    output logic              pin_en_o,
    output logic [PER_W-1:0]  per_m_o,
    output logic [PER_W-1:0]  per_a_o,
    output logic [MISS_W-1:0] miss_m_o,
    output logic [MISS_W-1:0] miss_a_o,
    output logic [NSTAT-1:0]  sticky_o,
    output logic [NSTAT-1:0]  ien_o
);
    localparam logic [PER_W-1:0]  PER_RST  = PER_W'(16);
    localparam logic [MISS_W-1:0] MISS_RST = MISS_W'(2);

    typedef struct packed {
        logic              policy;
        logic              pin_en;
        logic [PER_W-1:0]  per_m;
        logic [PER_W-1:0]  per_a;
        logic [MISS_W-1:0] miss_m;
        logic [MISS_W-1:0] miss_a;
        logic [NSTAT-1:0]  sticky;
        logic [NSTAT-1:0]  ien;
    } regs_t;

    regs_t            rg_d, rg_q;
    logic [NSTAT-1:0] clr;
    logic             unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_comb begin
        rg_d = rg_q;
        clr  = '0;
        if (wr_en_i) begin
            unique case (addr_i)
                A_CTRL: begin
                    rg_d.policy = wdata_i[0];
                    rg_d.pin_en = wdata_i[1];
                end
                A_PER_M: rg_d.per_m = wdata_i[PER_W-1:0];
                A_PER_A: rg_d.per_a = wdata_i[PER_W-1:0];
                A_MISS: begin
                    rg_d.miss_m = wdata_i[MISS_W-1:0];
                    rg_d.miss_a = wdata_i[MISS_AOFS+MISS_W-1:MISS_AOFS];
                end
                A_STAT:  clr = wdata_i[NSTAT-1:0];
                A_IEN:   rg_d.ien = wdata_i[NSTAT-1:0];
                default: ;
            endcase
        end
        rg_d.sticky = (rg_q.sticky & ~clr) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q <= '{policy: 1'b0, pin_en: 1'b0, per_m: PER_RST, per_a: PER_RST,
                      miss_m: MISS_RST, miss_a: MISS_RST, sticky: '0, ien: '0};
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            unique case (addr_i)
                A_CTRL:  rdata_o = DW'({rg_q.pin_en, rg_q.policy});
                A_PER_M: rdata_o = DW'(rg_q.per_m);
                A_PER_A: rdata_o = DW'(rg_q.per_a);
                A_MISS: begin
                    rdata_o[MISS_W-1:0]                   = rg_q.miss_m;
                    rdata_o[MISS_AOFS+MISS_W-1:MISS_AOFS] = rg_q.miss_a;
                end
                A_STAT:  rdata_o = DW'(rg_q.sticky);
                A_IEN:   rdata_o = DW'(rg_q.ien);
                A_LIVE:  rdata_o = DW'(live_i);
                default: rdata_o = '0;
            endcase
        end
    end

    assign policy_o = rg_q.policy;
    assign pin_en_o = rg_q.pin_en;
    assign per_m_o  = rg_q.per_m;
    assign per_a_o  = rg_q.per_a;
    assign miss_m_o = rg_q.miss_m;
    assign miss_a_o = rg_q.miss_a;
    assign sticky_o = rg_q.sticky;
    assign ien_o    = rg_q.ien;

    assert_fail_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.sticky[SB_FAIL] && !clr[SB_FAIL]) |=> rg_q.sticky[SB_FAIL]);

    assert_fail_main_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rg_q.sticky[SB_FAIL] && !set_i[SB_FAIL]) |=> !rg_q.sticky[SB_FAIL]);

endmodule

// File: rtl/ref_activity_mon.sv
module ref_activity_mon
    import actmon_pkg::*;
#(
    parameter int DW     = 16,
    parameter int AW     = 3,
    parameter int PER_W  = 16,
    parameter int MISS_W = 3,
    parameter int SYNC_N = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_main_i,
    input  logic          ref_aux_i,
    input  logic          main_locked_i,
    input  logic          aux_locked_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          main_hold_o,
    output logic          main_wide_o,
    output logic          aux_hold_o,
    output logic          aux_wide_o,
    output logic          aux_lock_o,
    output logic          irq_o,
    output logic          fail_pin_o
);
    localparam int NCH   = 2;
    localparam int LIM_W = PER_W + MISS_W;

    logic              policy, pin_en;
    logic [PER_W-1:0]  per_m, per_a;
    logic [MISS_W-1:0] miss_m, miss_a;
    logic [NSTAT-1:0]  sticky, ien, set_bits;
    logic [3:0]        live;

    logic [NCH-1:0]    ref_in, locked_in, rise, hold, wide, evt, chg;
    logic [PER_W-1:0]  per   [NCH];
    logic [MISS_W-1:0] miss  [NCH];
    logic [LIM_W-1:0]  lim   [NCH];

    assign ref_in    = {ref_aux_i, ref_main_i};
    assign locked_in = {aux_locked_i, main_locked_i};
    assign per[0]    = per_m;
    assign per[1]    = per_a;
    assign miss[0]   = miss_m;
    assign miss[1]   = miss_a;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign lim[c] = LIM_W'(per[c]) * LIM_W'(miss[c]);

        actmon_sync #(.STAGES(SYNC_N)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .async_i(ref_in[c]),
            .rise_o (rise[c])
        );

        actmon_chan #(.LIM_W(LIM_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .edge_i  (rise[c]),
            .lim_i   (lim[c]),
            .policy_i(policy),
            .locked_i(locked_in[c]),
            .hold_o  (hold[c]),
            .wide_o  (wide[c]),
            .evt_o   (evt[c]),
            .chg_o   (chg[c])
        );
    end

    assign set_bits[SB_FAIL]  = evt[0];
    assign set_bits[SB_MLOL]  = chg[0];
    assign set_bits[SB_ALOCK] = chg[1];

    assign live = {~wide[1], hold[1], wide[0], hold[0]};

    actmon_regs #(
        .DW(DW), .AW(AW), .PER_W(PER_W), .MISS_W(MISS_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .set_i   (set_bits),
        .live_i  (live),
        .policy_o(policy),
        .pin_en_o(pin_en),
        .per_m_o (per_m),
        .per_a_o (per_a),
        .miss_m_o(miss_m),
        .miss_a_o(miss_a),
        .sticky_o(sticky),
        .ien_o   (ien)
    );

    assign main_hold_o = hold[0];
    assign main_wide_o = wide[0];
    assign aux_hold_o  = hold[1];
    assign aux_wide_o  = wide[1];
    assign aux_lock_o  = ~wide[1];
    assign irq_o       = |(sticky & ien);
    assign fail_pin_o  = pin_en & sticky[SB_FAIL];

endmodule

// File: tb/ref_activity_mon_tb.sv
module ref_activity_mon_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_r [2];
    logic        main_locked = 1'b0, aux_locked = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        main_hold, main_wide, aux_hold, aux_wide, aux_lock, irq, fail_pin;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0, cmp_en = 0;

    always #5 clk = ~clk;

    ref_activity_mon u_dut (
        .clk(clk), .rst_n(rst_n),
        .ref_main_i(ref_r[0]), .ref_aux_i(ref_r[1]),
        .main_locked_i(main_locked), .aux_locked_i(aux_locked),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata),
        .main_hold_o(main_hold), .main_wide_o(main_wide),
        .aux_hold_o(aux_hold), .aux_wide_o(aux_wide), .aux_lock_o(aux_lock),
        .irq_o(irq), .fail_pin_o(fail_pin)
    );

    // reference generators, driven on the falling edge
    bit run [2];
    int half [2];
    int hc [2];
    initial begin
        for (int c = 0; c < 2; c++) begin
            ref_r[c] = 1'b0; run[c] = 0; half[c] = 4; hc[c] = 0;
        end
    end
    always @(negedge clk) begin
        for (int c = 0; c < 2; c++) begin
            if (run[c]) begin
                if (hc[c] >= half[c] - 1) begin
                    ref_r[c] = ~ref_r[c];
                    hc[c] = 0;
                end else hc[c]++;
            end
        end
    end

    // behavioural reference model
    int m_pipe [2][$];   // sampled reference levels, newest first
    int m_cnt [2], m_st [2];   // 0 track, 1 hold near, 2 hold lol, 3 relock
    bit m_evt [2], m_chg [2];
    int m_sticky, m_ien, m_per [2], m_miss [2];
    bit m_policy, m_pinen;

    function automatic bit wide_of(int s); return s == 2 || s == 3; endfunction
    function automatic bit hold_of(int s); return s == 1 || s == 2; endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_pipe[c] = '{0, 0, 0};
            m_cnt[c] = 0; m_st[c] = 0; m_evt[c] = 0; m_chg[c] = 0;
            m_per[c] = 16; m_miss[c] = 2;
        end
        m_sticky = 0; m_ien = 0; m_policy = 0; m_pinen = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) model_reset();
        else begin
            int clr;
            int nst [2];
            bit nevt [2], nchg [2];
            clr = (wr_en && addr == 3'd4) ? int'(wdata[2:0]) : 0;
            for (int c = 0; c < 2; c++) begin
                int lim;
                bit rise, exp_now;
                lim = m_per[c] * m_miss[c];
                rise = (m_pipe[c][1] == 1) && (m_pipe[c][2] == 0);
                exp_now = (lim != 0) && (m_cnt[c] >= lim);
                nst[c] = m_st[c]; nevt[c] = 0;
                case (m_st[c])
                    0: if (exp_now) begin nst[c] = m_policy ? 2 : 1; nevt[c] = 1; end
                    1: if (rise) nst[c] = 0;
                    2: if (rise) nst[c] = 3;
                    3: if (exp_now) begin nst[c] = 2; nevt[c] = 1; end
                       else if ((c == 0) ? main_locked : aux_locked) nst[c] = 0;
                    default: ;
                endcase
                nchg[c] = wide_of(nst[c]) != wide_of(m_st[c]);
                if (rise) m_cnt[c] = 0;
                else if (m_cnt[c] < lim) m_cnt[c]++;
            end
            m_sticky = (m_sticky & ~clr) | (m_evt[0] ? 1 : 0) | (m_chg[0] ? 2 : 0) | (m_chg[1] ? 4 : 0);
            for (int c = 0; c < 2; c++) begin
                m_st[c] = nst[c]; m_evt[c] = nevt[c]; m_chg[c] = nchg[c];
                m_pipe[c].push_front(int'(ref_r[c]));
                void'(m_pipe[c].pop_back());
            end
            if (wr_en) begin
                case (addr)
                    3'd0: begin m_policy = wdata[0]; m_pinen = wdata[1]; end
                    3'd1: m_per[0] = wdata;
                    3'd2: m_per[1] = wdata;
                    3'd3: begin m_miss[0] = wdata[2:0]; m_miss[1] = wdata[10:8]; end
                    3'd5: m_ien = wdata[2:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic check(int got, int exp, string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0d exp %0d (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check(main_hold, hold_of(m_st[0]), "R1 main_hold");
            check(main_wide, wide_of(m_st[0]), "R4 main_wide");
            check(aux_hold,  hold_of(m_st[1]), "R8 aux_hold");
            check(aux_lock,  !wide_of(m_st[1]), "R8 aux_lock");
            check(irq, (m_sticky & m_ien) != 0, "R6 irq");
            check(fail_pin, m_pinen && m_sticky[0], "R7 fail_pin");
        end
    end

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog got cycle %0d exp below 150000", cyc);
            finish_run();
        end
    end

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(logic [2:0] a, int exp, string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        check(int'(rdata), exp, tag);
        rd_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1;
        // R9 reset values
        check(main_hold, 0, "R9 reset main_hold");
        rd_chk(3'd0, 0, "R9 ctrl");
        rd_chk(3'd1, 16, "R9 per main");
        rd_chk(3'd2, 16, "R9 per aux");
        rd_chk(3'd3, 16'h0202, "R9 miss");
        rd_chk(3'd4, 0, "R9 status");
        rd_chk(3'd5, 0, "R9 ien");

        // R1/R10: steady ref period 8 clocks, limit 8*2 = 16
        wr(3'd1, 16'd8);
        half[0] = 4; run[0] = 1;
        half[1] = 4; run[1] = 1;
        idle(200);
        check(main_hold, 0, "R1 active ref no hold");
        run[0] = 0;
        idle(40);
        check(main_hold, 1, "R1 hold after missing edges");
        rd_chk(3'd4, 1, "R5 fail sticky set");
        check(main_wide, 0, "R3 near mode in hold");
        // R3 recovery
        run[0] = 1;
        idle(20);
        check(main_hold, 0, "R3 hold released on edge");
        rd_chk(3'd4, 1, "R5 sticky survives recovery");
        // R5 write-1-clear, write-0 no effect
        wr(3'd4, 16'h0000);
        rd_chk(3'd4, 1, "R5 write 0 keeps");
        wr(3'd4, 16'h0001);
        rd_chk(3'd4, 0, "R5 write 1 clears");
        // R6/R7
        wr(3'd5, 16'h0001);
        wr(3'd0, 16'h0002);
        check(irq, 0, "R6 irq low before event");
        run[0] = 0; idle(40);
        check(irq, 1, "R6 irq on enabled fail");
        check(fail_pin, 1, "R7 pin mirrors fail");
        wr(3'd0, 16'h0000);
        check(fail_pin, 0, "R7 pin disabled");
        wr(3'd5, 16'h0000);
        check(irq, 0, "R6 irq masked");
        run[0] = 1; idle(20);
        wr(3'd4, 16'h0007);

        // R4 loss-of-lock policy
        wr(3'd0, 16'h0001);
        main_locked = 1'b0;
        run[0] = 0; idle(40);
        check(main_wide, 1, "R4 wide on event");
        rd_chk(3'd4, 3, "R4 state change bit set");
        run[0] = 1; idle(30);
        check(main_hold, 0, "R4 hold released");
        check(main_wide, 1, "R4 wide until lock");
        main_locked = 1'b1; idle(3);
        check(main_wide, 0, "R4 wide clears on lock");
        wr(3'd4, 16'h0007);
        main_locked = 1'b0;

        // R8 auxiliary channel with policy 1, limit 16*4
        wr(3'd2, 16'd16);
        wr(3'd3, 16'h0402);
        half[1] = 8; idle(100);
        wr(3'd4, 16'h0007);
        run[1] = 0; idle(90);
        check(aux_hold, 1, "R8 aux hold");
        check(aux_lock, 0, "R8 aux lock dropped");
        rd_chk(3'd4, 4, "R8 aux sets bit2 not bit0");
        rd_chk(3'd6, 4'b0100, "R9 live readback");
        run[1] = 1; idle(40);
        aux_locked = 1'b1; idle(3);
        check(aux_lock, 1, "R8 aux relocked");
        aux_locked = 1'b0;
        wr(3'd4, 16'h0007);

        // R2 zero limit disables main channel
        wr(3'd3, 16'h0400);
        run[0] = 0; idle(300);
        check(main_hold, 0, "R2 zero limit no hold");
        rd_chk(3'd4, 0, "R2 no status");
        // re-arm with small limit: period 3 * miss 1
        wr(3'd1, 16'd3);
        wr(3'd3, 16'h0401);
        idle(10);
        check(main_hold, 1, "R1 small limit expires");
        idle(5);
        finish_run();
    end

endmodule